// File: doc/BRIEF.md
# Sequential Integer Divider with Remainder

This block divides one 32-bit operand by another over several clock cycles and returns both the quotient and the remainder, together with zero, sign and overflow flags. It serves an execution pipeline that writes the quotient and the remainder to two different destination registers. The pipeline does that write-back itself. The unit works in signed or unsigned arithmetic. Each of the two has a full-word form and a halfword form.

An operation starts with a one-cycle `start` pulse that carries the operands and the mode. The unit spends one cycle preparing the operands, 32 cycles producing one quotient bit each, and one cycle applying signs and flags. During those cycles `busy` is high. In the cycle after the last of them, `done` pulses for one cycle. The results are held until the next operation finishes.

A zero divisor, or the signed case of the most negative dividend over minus one, does not trap. The unit raises overflow and divides by one instead. The unit never computes a carry flag, so the carry of the surrounding status word is left as it was.

Top module: `sdiv_unit`

## Requirements
- R1: A `start` seen while `busy` is low is accepted at that clock edge. `busy` is then high for exactly 34 cycles. `done` is high for exactly one cycle, the cycle after the last busy cycle, and `busy` is low while `done` is high.
- R2: A `start` seen while `busy` is high is ignored. The running operation completes on schedule with its own operands.
- R3: With `mode` = 2'b00 (unsigned, full word), the quotient is dividend / divisor and the remainder is dividend mod divisor, both taken as unsigned 32-bit values.
- R4: With `mode` = 2'b01 (signed, full word), the operands are two's complement. The quotient truncates toward zero, and the remainder carries the sign of the dividend.
- R5: With `mode` = 2'b10 (unsigned, halfword), the divisor is replaced by its low 16 bits, zero-extended. The upper 16 bits of the divisor have no effect.
- R6: With `mode` = 2'b11 (signed, halfword), the dividend is replaced by its low 16 bits, sign-extended. The full 32-bit divisor is used.
- R7: If the effective divisor is zero, the overflow flag is set and the division is done with a divisor of 1. The quotient is then the effective dividend and the remainder is 0.
- R8: In the signed modes, an effective dividend of 0x80000000 with a divisor of 0xFFFFFFFF sets the overflow flag and divides by 1. The quotient is then 0x80000000 and the remainder is 0.
- R9: At `done`, the zero flag is set exactly when the quotient is 0 and the sign flag equals quotient bit 31. The overflow flag is set only in the cases of R7 and R8.
- R10: The quotient, remainder and flag outputs change only in the `done` cycle and hold their values at all other times.
- R11: After reset, `busy` and `done` are low, and the quotient, remainder and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode | input | 2 | Bit 0: signed arithmetic; bit 1: halfword variant |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results valid and updated |
| quotient | output | 32 | Quotient result |
| remainder | output | 32 | Remainder result |
| flag_zero | output | 1 | Quotient is zero |
| flag_sign | output | 1 | Quotient bit 31 |
| flag_ovf | output | 1 | Divide-by-zero or signed overflow occurred |

## Verification
`busy` and `done` are due on fixed cycles. `busy` is due on the cycle after `start` is accepted and stays for 34 cycles. `done` is due 34 clock edges after acceptance, and the new quotient, remainder and flags appear on that same edge. The bench keeps its own countdown, started from the accepted `start`, and compares `busy` and `done` against it at every falling edge. It compares the results exactly when its countdown says `done` is due. On every other cycle it checks that the outputs still equal the last delivered result.

// File: rtl/sdiv_pkg.sv
// Shared types for the sequential divider.
// Assumes: one FSM encoding shared by the top module and nothing else.
package sdiv_pkg;
    // Sequencer phases of one division
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_ITER  = 2'd2,
        PH_FIX   = 2'd3
    } sdiv_phase_e;

    // Mode bit positions
    localparam int MB_SIGNED = 0;
    localparam int MB_HALF   = 1;
endpackage

// File: rtl/sdiv_prep.sv
// Operand preparation: applies the halfword variants, detects the
// overflow cases (zero divisor, signed min over -1), substitutes divisor 1
// for them and converts both operands to magnitudes with result signs.
// Assumes: W is even; purely combinational.
module sdiv_prep #(
    parameter int W = 32
) (
    input  logic [1:0]   mode,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] dvd_mag,
    output logic [W-1:0] dsr_mag,
    output logic         neg_q,
    output logic         neg_r,
    output logic         ovf
);
    import sdiv_pkg::*;
    localparam int H = W / 2;
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    logic          sgn, half;
    logic [W-1:0]  a_eff, b_eff, b_use;
    logic          neg_a, neg_b;

    // Select effective operands, overflow substitution and magnitudes
    always_comb begin
        sgn   = mode[MB_SIGNED];
        half  = mode[MB_HALF];
        a_eff = (sgn && half) ? {{H{a_in[H-1]}}, a_in[H-1:0]} : a_in;
        b_eff = (!sgn && half) ? {{H{1'b0}}, b_in[H-1:0]} : b_in;
        ovf   = (b_eff == '0) ||
                (sgn && (b_eff == '1) && (a_eff == MIN_NEG));
        b_use = ovf ? ONE : b_eff;
        neg_a = sgn && a_eff[W-1];
        neg_b = sgn && b_use[W-1];
        dvd_mag = neg_a ? (~a_eff + ONE) : a_eff;
        dsr_mag = neg_b ? (~b_use + ONE) : b_use;
        neg_q = neg_a ^ neg_b;
        neg_r = neg_a;
    end
endmodule

// File: rtl/sdiv_step.sv
// One restoring-division step: shifts the next dividend bit into the
// partial remainder and retires one quotient bit.
// Assumes: rem < dsr on entry, so the result remainder fits in W bits.
module sdiv_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] quo,
    input  logic [W-1:0] dsr,
    output logic [W-1:0] rem_n,
    output logic [W-1:0] quo_n
);
    logic [W:0] shifted;
    logic [W:0] trial;

    // Trial subtract and restore on borrow
    always_comb begin
        shifted = {rem, quo[W-1]};
        trial   = shifted - {1'b0, dsr};
        if (trial[W]) begin
            rem_n = shifted[W-1:0];
            quo_n = {quo[W-2:0], 1'b0};
        end else begin
            rem_n = trial[W-1:0];
            quo_n = {quo[W-2:0], 1'b1};
        end
    end
endmodule

// File: rtl/sdiv_fix.sv
// Result fixup: re-applies signs to the magnitudes and derives flags.
// Assumes: magnitudes come from a completed restoring loop; combinational.
module sdiv_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic         neg_q,
    input  logic         neg_r,
    input  logic         ovf_in,
    output logic [W-1:0] quo_out,
    output logic [W-1:0] rem_out,
    output logic         zero,
    output logic         sign,
    output logic         ovf
);
    // Negate where required and compute status flags
    always_comb begin
        quo_out = neg_q ? (~quo_mag + 1'b1) : quo_mag;
        rem_out = neg_r ? (~rem_mag + 1'b1) : rem_mag;
        zero    = (quo_out == '0);
        sign    = quo_out[W-1];
        ovf     = ovf_in;
    end
endmodule

// File: rtl/sdiv_unit.sv
// Sequential integer divider, top level. One setup cycle, W restoring
// iterations and one fixup cycle; busy covers all of them, done pulses
// once afterwards and the result registers hold until the next done.
// Assumes: start is only honoured while idle; carry is never produced.
module sdiv_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         flag_zero,
    output logic         flag_sign,
    output logic         flag_ovf
);
    import sdiv_pkg::*;
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    sdiv_phase_e  phase;
    logic [1:0]   mode_r;
    logic [W-1:0] a_r, b_r;
    logic [W-1:0] rem_r, quo_r, dsr_r;
    logic         negq_r, negr_r, ovf_r;
    logic [CW-1:0] cnt_r;
    logic         done_r;
    logic [W-1:0] q_o, r_o;
    logic         z_o, s_o, v_o;

    logic [W-1:0] p_dvd, p_dsr;
    logic         p_negq, p_negr, p_ovf;
    logic [W-1:0] s_rem, s_quo;
    logic [W-1:0] f_quo, f_rem;
    logic         f_zero, f_sign, f_ovf;

    sdiv_prep #(.W(W)) u_prep (
        .mode    (mode_r),
        .a_in    (a_r),
        .b_in    (b_r),
        .dvd_mag (p_dvd),
        .dsr_mag (p_dsr),
        .neg_q   (p_negq),
        .neg_r   (p_negr),
        .ovf     (p_ovf)
    );

    sdiv_step #(.W(W)) u_step (
        .rem   (rem_r),
        .quo   (quo_r),
        .dsr   (dsr_r),
        .rem_n (s_rem),
        .quo_n (s_quo)
    );

    sdiv_fix #(.W(W)) u_fix (
        .quo_mag (quo_r),
        .rem_mag (rem_r),
        .neg_q   (negq_r),
        .neg_r   (negr_r),
        .ovf_in  (ovf_r),
        .quo_out (f_quo),
        .rem_out (f_rem),
        .zero    (f_zero),
        .sign    (f_sign),
        .ovf     (f_ovf)
    );

    // Sequencer and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            mode_r <= '0;
            a_r    <= '0;
            b_r    <= '0;
            rem_r  <= '0;
            quo_r  <= '0;
            dsr_r  <= '0;
            negq_r <= 1'b0;
            negr_r <= 1'b0;
            ovf_r  <= 1'b0;
            cnt_r  <= '0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        mode_r <= mode;
                        a_r    <= dividend;
                        b_r    <= divisor;
                        phase  <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    quo_r  <= p_dvd;
                    rem_r  <= '0;
                    dsr_r  <= p_dsr;
                    negq_r <= p_negq;
                    negr_r <= p_negr;
                    ovf_r  <= p_ovf;
                    cnt_r  <= '0;
                    phase  <= PH_ITER;
                end
                PH_ITER: begin
                    rem_r <= s_rem;
                    quo_r <= s_quo;
                    cnt_r <= cnt_r + 1'b1;
                    if (cnt_r == LAST) begin
                        phase <= PH_FIX;
                    end
                end
                default: begin
                    done_r <= 1'b1;
                    phase  <= PH_IDLE;
                end
            endcase
        end
    end

    // Result registers, loaded only on the fixup cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
            r_o <= '0;
            z_o <= 1'b0;
            s_o <= 1'b0;
            v_o <= 1'b0;
        end else if (phase == PH_FIX) begin
            q_o <= f_quo;
            r_o <= f_rem;
            z_o <= f_zero;
            s_o <= f_sign;
            v_o <= f_ovf;
        end
    end

    assign busy      = (phase != PH_IDLE);
    assign done      = done_r;
    assign quotient  = q_o;
    assign remainder = r_o;
    assign flag_zero = z_o;
    assign flag_sign = s_o;
    assign flag_ovf  = v_o;
endmodule

// File: rtl/sdiv_unit_chk.sv
// Protocol and result checker for sdiv_unit, attached by bind.
// Assumes: observes ports only; keeps its own copy of accepted operands.
module sdiv_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   mode,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         flag_zero,
    input logic         flag_sign,
    input logic         flag_ovf
);
    localparam int H   = W / 2;
    localparam int LAT = W + 2;
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    logic [7:0]   run_cnt;
    logic [1:0]   m_cap;
    logic [W-1:0] a_cap, b_cap;
    logic [W-1:0] a_eff, b_eff;

    // Count busy cycles of the current run
    always_ff @(posedge clk) begin
        if (!rst_n)                 run_cnt <= '0;
        else if (!busy)             run_cnt <= '0;
        else if (run_cnt != 8'hFF)  run_cnt <= run_cnt + 1'b1;
    end

    // Capture operands of each accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_cap <= '0;
            a_cap <= '0;
            b_cap <= '0;
        end else if (start && !busy) begin
            m_cap <= mode;
            a_cap <= dividend;
            b_cap <= divisor;
        end
    end

    // Effective operands per mode
    always_comb begin
        a_eff = (m_cap == 2'b11) ? {{H{a_cap[H-1]}}, a_cap[H-1:0]} : a_cap;
        b_eff = (m_cap == 2'b10) ? {{H{1'b0}}, b_cap[H-1:0]} : b_cap;
    end

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                                   // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R1
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                              // R1
    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == 8'(LAT)));                               // R1
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_cnt < 8'(LAT - 1)) |=> busy);                    // R2
    AST_UNS_REM: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !m_cap[0] && !flag_ovf) |-> (remainder < b_eff));    // R3
    AST_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (done && b_eff == '0) |-> (flag_ovf && remainder == '0 && quotient == a_eff)); // R7
    AST_MIN_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (done && m_cap[0] && b_eff == '1 && a_eff == MIN_NEG)
            |-> (flag_ovf && quotient == MIN_NEG && remainder == '0)); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(flag_zero)
                   && $stable(flag_sign) && $stable(flag_ovf)));      // R10
endmodule

bind sdiv_unit sdiv_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .flag_zero (flag_zero),
    .flag_sign (flag_sign),
    .flag_ovf  (flag_ovf)
);

// File: tb/sdiv_unit_tb.sv
// Self-checking bench: behavioural divide model plus a per-cycle
// busy/done countdown, compared at every falling edge.
module sdiv_unit_tb;
    localparam int LAT = 34;
    localparam logic [1:0] M_UF = 2'b00, M_SF = 2'b01, M_UH = 2'b10, M_SH = 2'b11;

    typedef struct {
        logic [31:0] q;
        logic [31:0] r;
        logic        z;
        logic        s;
        logic        o;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = '0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done, flag_zero, flag_sign, flag_ovf;
    logic [31:0] quotient, remainder;

    int n_chk = 0;
    int n_err = 0;
    string cur_tag = "R3";

    exp_t exp_q[$];
    exp_t last;
    bit   have_last = 0;
    int   m_left = 0;
    bit   m_done = 0;

    always #2 clk = ~clk;

    sdiv_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder),
        .flag_zero(flag_zero), .flag_sign(flag_sign), .flag_ovf(flag_ovf)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Behavioural reference result
    function automatic exp_t ref_div(input logic [1:0] m, input logic [31:0] a,
                                     input logic [31:0] b, input string tag);
        exp_t e;
        logic [31:0] aa, bb;
        longint sa, sb;
        aa = a;
        bb = b;
        if (m == M_SH) aa = {{16{a[15]}}, a[15:0]};
        if (m == M_UH) bb = {16'h0, b[15:0]};
        if (bb == 0 || (m[0] && bb == 32'hFFFF_FFFF && aa == 32'h8000_0000)) begin
            e.o = 1; e.q = aa; e.r = 0;
        end else if (m[0]) begin
            e.o = 0;
            sa = longint'($signed(aa));
            sb = longint'($signed(bb));
            e.q = 32'(sa / sb);
            e.r = 32'(sa % sb);
        end else begin
            e.o = 0; e.q = aa / bb; e.r = aa % bb;
        end
        e.z = (e.q == 0);
        e.s = e.q[31];
        e.tag = tag;
        return e;
    endfunction

    // Cycle model: accept, count down, flag done
    always @(posedge clk) begin
        if (!rst_n) begin
            m_left <= 0;
            m_done <= 0;
        end else begin
            m_done <= 0;
            if (m_left == 0 && start) begin
                m_left <= LAT;
                exp_q.push_back(ref_div(mode, dividend, divisor, cur_tag));
            end else if (m_left > 0) begin
                m_left <= m_left - 1;
                if (m_left == 1) m_done <= 1;
            end
        end
    end

    // Compare against the model every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1", "busy", {31'b0, busy}, {31'b0, (m_left != 0)});
            chk("R1", "done", {31'b0, done}, {31'b0, m_done});
            if (m_done && exp_q.size() > 0) begin
                last = exp_q.pop_front();
                have_last = 1;
                chk(last.tag, "quotient", quotient, last.q);
                chk(last.tag, "remainder", remainder, last.r);
                chk("R9", "zero", {31'b0, flag_zero}, {31'b0, last.z});
                chk("R9", "sign", {31'b0, flag_sign}, {31'b0, last.s});
                chk("R9", "ovf", {31'b0, flag_ovf}, {31'b0, last.o});
            end else if (have_last) begin
                chk("R10", "hold quotient", quotient, last.q);
                chk("R10", "hold remainder", remainder, last.r);
                chk("R10", "hold ovf", {31'b0, flag_ovf}, {31'b0, last.o});
            end
        end
    end

    task automatic issue(input logic [1:0] m, input logic [31:0] a,
                         input logic [31:0] b, input string tag);
        cur_tag = tag;
        mode = m; dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] m, input logic [31:0] a,
                          input logic [31:0] b, input string tag);
        issue(m, a, b, tag);
        while (m_left != 0 || m_done) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11", "busy", {31'b0, busy}, 32'd0);
        chk("R11", "done", {31'b0, done}, 32'd0);
        chk("R11", "quotient", quotient, 32'd0);
        chk("R11", "remainder", remainder, 32'd0);
        chk("R11", "flags", {29'b0, flag_zero, flag_sign, flag_ovf}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(M_UF, 32'd100, 32'd7, "R3");
        run_op(M_UF, 32'hFFFF_FFFF, 32'd1, "R3");
        run_op(M_UF, 32'd5, 32'd10, "R3");
        run_op(M_UF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
        run_op(M_SF, 32'hFFFF_FFF9, 32'd2, "R4");
        run_op(M_SF, 32'd7, 32'hFFFF_FFFE, "R4");
        run_op(M_SF, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R4");
        run_op(M_SF, 32'h8000_0000, 32'd2, "R4");
        run_op(M_UH, 32'h1234_5678, 32'hFFFF_0010, "R5");
        run_op(M_UH, 32'h0000_FFFF, 32'h7777_0003, "R5");
        run_op(M_SH, 32'h1234_FFF9, 32'd2, "R6");
        run_op(M_SH, 32'h0000_8000, 32'hFFFF_FFFF, "R6");
        run_op(M_SH, 32'hABCD_0064, 32'hFFFF_FFF6, "R6");
        run_op(M_UF, 32'hDEAD_BEEF, 32'd0, "R7");
        run_op(M_SF, 32'hFFFF_FF00, 32'd0, "R7");
        run_op(M_UH, 32'h0000_1234, 32'h0001_0000, "R7");
        run_op(M_SH, 32'h0000_8001, 32'd0, "R7");
        run_op(M_SF, 32'h8000_0000, 32'hFFFF_FFFF, "R8");
        run_op(M_UF, 32'h8000_0000, 32'hFFFF_FFFF, "R3");
        run_op(M_SF, 32'd0, 32'd9, "R9");

        // R2: start while busy is ignored
        issue(M_UF, 32'd1000, 32'd3, "R2");
        repeat (5) @(negedge clk);
        mode = M_SF; dividend = 32'd77; divisor = 32'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_left != 0 || m_done) @(negedge clk);

        // R1: back-to-back start in the done cycle
        issue(M_UF, 32'd90, 32'd9, "R1");
        while (!m_done) @(negedge clk);
        issue(M_UF, 32'd91, 32'd10, "R1");
        while (m_left != 0 || m_done) @(negedge clk);

        for (int i = 0; i < 40; i++) begin
            logic [1:0] rm;
            rm = 2'($urandom_range(0, 3));
            run_op(rm, $urandom, (i % 5 == 0) ? 32'($urandom_range(0, 20)) : $urandom,
                   rm == M_UF ? "R3" : rm == M_SF ? "R4" : rm == M_UH ? "R5" : "R6");
        end

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule